// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block is a real-time clock peripheral that sits on a simple single-cycle 32-bit register bus. It keeps a seconds count that moves up by one on each one-second enable pulse. The pulse comes either from an external tick pin or from an internal prescaler that divides the system clock. Software can preset the count, stop and restart it, and program a compare value.

When the count steps onto the compare value, a sticky raw flag is raised whether or not the interrupt is enabled. An enable bit gates that flag onto a masked status bit, and the same gated signal drives a level-sensitive interrupt line. Writing a one to the acknowledge register lowers the flag.

Registers are word-aligned, and bits [4:2] of the byte address select them: 0x00 count (read), 0x04 compare, 0x08 preset, 0x0C run control, 0x10 interrupt enable, 0x14 raw flag, 0x18 masked flag, 0x1C acknowledge. Read data is combinational from the address in the same cycle. A write takes effect at the clock edge where `bus_we` is high.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count reads 0, run control reads 1, interrupt enable reads 0, the raw and masked flags read 0 and `irq` is low.
- R2: A write to the preset register (0x08) makes the count equal the written value from the next cycle. The preset register reads back the last value written. A preset write wins over a tick in the same cycle.
- R3: While run control bit 0 is 1, each tick adds one to the count. 0xFFFFFFFF wraps to 0. Without a tick the count holds.
- R4: While run control bit 0 is 0, ticks leave the count unchanged. Bit 0 of run control (0x0C) reads back the last value written.
- R5: The raw flag (0x14, bit 0) becomes 1 on the tick at which the count steps onto the compare value (0x04), regardless of the enable bit. It then stays 1 until acknowledged. Writing the compare value, or presetting the count to it, does not set the flag.
- R6: The masked flag (0x18, bit 0) and `irq` both equal the raw flag AND interrupt enable bit 0 (0x10).
- R7: Writing 0x1C with bit 0 set clears the raw flag, and bit 0 clear has no effect. If an acknowledge and a new compare hit fall in the same cycle, the flag ends up set.
- R8: Bits [31:1] of the run control, enable, raw and masked registers read 0 and ignore writes. The acknowledge register reads 0.
- R9: With the internal prescaler selected, the count advances once every PRESCALE_DIV clock cycles, first reaching 1 PRESCALE_DIV cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, same cycle |
| tick_in | input | 1 | One-cycle seconds pulse, used when USE_EXT_TICK is 1 |
| irq | output | 1 | Level interrupt, raw flag gated by the enable bit |

## Verification
Read data is combinational, so a read result is due in the cycle the address is presented. Every write, tick or acknowledge is due one edge later, on the count, on the flags and on `irq` together. The bench therefore drives each stimulus at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. For collisions (acknowledge with hit, preset with tick) both stimuli are applied in the same cycle. The prescaler variant is sampled one edge before and one edge at the expected step, so an off-by-one divide is caught.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // word index taken from byte address bits [4:2]
   typedef enum logic [2:0] {
      RI_COUNT  = 3'd0,
      RI_CMP    = 3'd1,
      RI_PRESET = 3'd2,
      RI_RUN    = 3'd3,
      RI_IEN    = 3'd4,
      RI_RAW    = 3'd5,
      RI_MSTAT  = 3'd6,
      RI_ACK    = 3'd7
   } rtc_reg_e;

   localparam int unsigned IDX_LSB = 2;
   localparam int unsigned IDX_MSB = 4;

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
   parameter bit          USE_EXT_TICK = 1'b1,
   parameter int unsigned PRESCALE_DIV = 50_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic tick_o
);

   localparam int unsigned PC_W = (PRESCALE_DIV <= 2) ? 1 : $clog2(PRESCALE_DIV);
   localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE_DIV - 1);

   if (PRESCALE_DIV < 2) begin : g_bad_div
      $error("rtc_tick_gen: PRESCALE_DIV must be at least 2");
   end

   if (USE_EXT_TICK) begin : g_ext
      logic unused_ext;
      assign unused_ext = clk & rst_n;
      assign tick_o = tick_i;
   end else begin : g_pre
      logic [PC_W-1:0] pc_q;
      logic            unused_pin;
      assign unused_pin = tick_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q <= '0;
         end else if (pc_q == PC_LAST) begin
            pc_q <= '0;
         end else begin
            pc_q <= pc_q + 1'b1;
         end
      end

      assign tick_o = (pc_q == PC_LAST);
   end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              preset_wr,
   input  logic [DATA_W-1:0] preset_val,
   input  logic [DATA_W-1:0] cmp_val,
   output logic [DATA_W-1:0] cnt_q,
   output logic              hit
);

   logic              step;
   logic [DATA_W-1:0] cnt_inc;

   assign step    = tick & run & ~preset_wr;
   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (preset_wr) begin
         cnt_q <= preset_val;
      end else if (step) begin
         cnt_q <= cnt_inc;
      end
   end

   // compare event: the count is about to step onto the compare value
   assign hit = step & (cnt_inc == cmp_val);

endmodule

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic ack_wr,
   input  logic ien,
   output logic raw_q,
   output logic mstat,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
      end else if (hit) begin
         raw_q <= 1'b1;
      end else if (ack_wr) begin
         raw_q <= 1'b0;
      end
   end

   assign mstat = raw_q & ien;
   assign irq   = mstat;

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] cnt,
   input  logic              raw,
   input  logic              mstat,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] cmp_q,
   output logic [DATA_W-1:0] preset_q,
   output logic              run_q,
   output logic              ien_q,
   output logic              preset_wr,
   output logic              ack_wr
);

   localparam logic [DATA_W-1:0] ZERO = '0;

   rtc_reg_e idx;
   logic     in_range;
   logic     wr;
   logic     unused_lo;

   assign idx       = rtc_reg_e'(bus_addr[IDX_MSB:IDX_LSB]);
   assign unused_lo = ^bus_addr[IDX_LSB-1:0];

   if (ADDR_W > IDX_MSB + 1) begin : g_hi
      assign in_range = (bus_addr[ADDR_W-1:IDX_MSB+1] == '0);
   end else begin : g_nohi
      assign in_range = 1'b1;
   end

   assign wr        = bus_we & in_range;
   assign preset_wr = wr & (idx == RI_PRESET);
   assign ack_wr    = wr & (idx == RI_ACK) & bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q    <= '0;
         preset_q <= '0;
         run_q    <= 1'b1;
         ien_q    <= 1'b0;
      end else if (wr) begin
         case (idx)
            RI_CMP:    cmp_q    <= bus_wdata;
            RI_PRESET: preset_q <= bus_wdata;
            RI_RUN:    run_q    <= bus_wdata[0];
            RI_IEN:    ien_q    <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = ZERO;
      if (in_range) begin
         case (idx)
            RI_COUNT:  bus_rdata = cnt;
            RI_CMP:    bus_rdata = cmp_q;
            RI_PRESET: bus_rdata = preset_q;
            RI_RUN:    bus_rdata = {ZERO[DATA_W-1:1], run_q};
            RI_IEN:    bus_rdata = {ZERO[DATA_W-1:1], ien_q};
            RI_RAW:    bus_rdata = {ZERO[DATA_W-1:1], raw};
            RI_MSTAT:  bus_rdata = {ZERO[DATA_W-1:1], mstat};
            default:   bus_rdata = ZERO;
         endcase
      end
   end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 5,
   parameter bit          USE_EXT_TICK = 1'b1,
   parameter int unsigned PRESCALE_DIV = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_in,
   output logic              irq
);

   if (DATA_W < 8) begin : g_bad_w
      $error("sec_rtc: DATA_W must be at least 8");
   end
   if (ADDR_W < 5) begin : g_bad_a
      $error("sec_rtc: ADDR_W must cover eight word registers");
   end

   logic              tick;
   logic              hit;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] cmp_q;
   logic [DATA_W-1:0] preset_q;
   logic              run_q;
   logic              ien_q;
   logic              preset_wr;
   logic              ack_wr;
   logic              raw_q;
   logic              mstat;

   rtc_tick_gen #(
      .USE_EXT_TICK (USE_EXT_TICK),
      .PRESCALE_DIV (PRESCALE_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_in),
      .tick_o (tick)
   );

   rtc_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .cnt       (cnt_q),
      .raw       (raw_q),
      .mstat     (mstat),
      .bus_rdata (bus_rdata),
      .cmp_q     (cmp_q),
      .preset_q  (preset_q),
      .run_q     (run_q),
      .ien_q     (ien_q),
      .preset_wr (preset_wr),
      .ack_wr    (ack_wr)
   );

   rtc_counter #(
      .DATA_W (DATA_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run_q),
      .preset_wr  (preset_wr),
      .preset_val (bus_wdata),
      .cmp_val    (cmp_q),
      .cnt_q      (cnt_q),
      .hit        (hit)
   );

   rtc_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit),
      .ack_wr (ack_wr),
      .ien    (ien_q),
      .raw_q  (raw_q),
      .mstat  (mstat),
      .irq    (irq)
   );

endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              tick,
   input logic              run_q,
   input logic              ien_q,
   input logic              raw_q,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] cmp_q
);

   logic in_rng;
   logic pre_w;
   logic ack_w;
   logic stepping;

   if (ADDR_W > 5) begin : g_hi
      assign in_rng = (bus_addr[ADDR_W-1:5] == '0);
   end else begin : g_nohi
      assign in_rng = 1'b1;
   end

   assign pre_w    = bus_we & in_rng & (bus_addr[4:2] == 3'd2);
   assign ack_w    = bus_we & in_rng & (bus_addr[4:2] == 3'd7) & bus_wdata[0];
   assign stepping = tick & run_q & ~pre_w;

   p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_w |=> cnt_q == $past(bus_wdata));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stepping |=> cnt_q == $past(cnt_q) + 1'b1);

   p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !pre_w) |=> $stable(cnt_q));

   p_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && (cnt_q + 1'b1 == cmp_q)) |=> raw_q);

   p_raw_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q && !ack_w) |=> raw_q);

   p_irq_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw_q && ien_q));

   p_mstat_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rng && bus_addr[4:2] == 3'd6) |-> bus_rdata[0] == irq);

   p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_w && !(stepping && (cnt_q + 1'b1 == cmp_q))) |=> !raw_q);

   p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rng && bus_addr[4:2] >= 3'd3) |-> bus_rdata[DATA_W-1:1] == '0);

endmodule

bind sec_rtc sec_rtc_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .tick      (tick),
   .run_q     (run_q),
   .ien_q     (ien_q),
   .raw_q     (raw_q),
   .cnt_q     (cnt_q),
   .cmp_q     (cmp_q)
);

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;

   localparam int unsigned DW  = 32;
   localparam int unsigned AW  = 5;
   localparam int unsigned DIV = 7;

   localparam logic [AW-1:0] A_COUNT  = 5'h00;
   localparam logic [AW-1:0] A_CMP    = 5'h04;
   localparam logic [AW-1:0] A_PRESET = 5'h08;
   localparam logic [AW-1:0] A_RUN    = 5'h0C;
   localparam logic [AW-1:0] A_IEN    = 5'h10;
   localparam logic [AW-1:0] A_RAW    = 5'h14;
   localparam logic [AW-1:0] A_MSTAT  = 5'h18;
   localparam logic [AW-1:0] A_ACK    = 5'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rst2_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          tick_in = 1'b0;
   logic          irq;
   logic [DW-1:0] pre_rdata;
   logic          pre_irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sec_rtc #(.DATA_W(DW), .ADDR_W(AW), .USE_EXT_TICK(1'b1), .PRESCALE_DIV(DIV)) u_sec_rtc (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in), .irq(irq));

   sec_rtc #(.DATA_W(DW), .ADDR_W(AW), .USE_EXT_TICK(1'b0), .PRESCALE_DIV(DIV)) u_sec_rtc_pre (
      .clk(clk), .rst_n(rst2_n), .bus_addr(A_COUNT), .bus_we(1'b0),
      .bus_wdata('0), .bus_rdata(pre_rdata), .tick_in(1'b0), .irq(pre_irq));

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // one bus write, optionally with a tick in the same cycle
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic tk = 1'b0);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick_in = tk;
      @(negedge clk);
      bus_we = 1'b0; tick_in = 1'b0; bus_wdata = '0;
   endtask

   task automatic tk1();
      @(negedge clk);
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string tag, input logic exp);
      #1;
      chk(tag, {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic t_reset();
      rd_chk("R1 count", A_COUNT, 0);
      rd_chk("R1 run", A_RUN, 1);
      rd_chk("R1 ien", A_IEN, 0);
      rd_chk("R1 raw", A_RAW, 0);
      rd_chk("R1 mstat", A_MSTAT, 0);
      irq_chk("R1 irq", 1'b0);
   endtask

   task automatic t_preset();
      wr(A_PRESET, 100);
      rd_chk("R2 count after preset", A_COUNT, 100);
      rd_chk("R2 preset readback", A_PRESET, 100);
   endtask

   task automatic t_count();
      for (int i = 0; i < 3; i++) tk1();
      rd_chk("R3 three ticks", A_COUNT, 103);
      repeat (5) @(negedge clk);
      rd_chk("R3 holds without tick", A_COUNT, 103);
   endtask

   task automatic t_run();
      wr(A_RUN, 0);
      rd_chk("R4 run readback 0", A_RUN, 0);
      tk1();
      rd_chk("R4 halted", A_COUNT, 103);
      wr(A_RUN, 32'hFFFF_FFFE);
      rd_chk("R8 run upper bits", A_RUN, 0);
      tk1();
      rd_chk("R4 still halted", A_COUNT, 103);
      wr(A_RUN, 1);
      tk1();
      rd_chk("R4 resumed", A_COUNT, 104);
   endtask

   task automatic t_match();
      wr(A_CMP, 106);
      rd_chk("R5 cmp readback", A_CMP, 106);
      tk1();
      rd_chk("R5 no flag before", A_RAW, 0);
      tk1();
      rd_chk("R5 count at match", A_COUNT, 106);
      rd_chk("R5 flag while disabled", A_RAW, 1);
      rd_chk("R6 mstat disabled", A_MSTAT, 0);
      irq_chk("R6 irq disabled", 1'b0);
      tk1();
      rd_chk("R5 sticky", A_RAW, 1);
   endtask

   task automatic t_mask();
      wr(A_IEN, 1);
      rd_chk("R6 mstat enabled", A_MSTAT, 1);
      irq_chk("R6 irq enabled", 1'b1);
      wr(A_IEN, 32'hFFFF_FFFE);
      rd_chk("R8 ien upper bits", A_IEN, 0);
      irq_chk("R6 irq off again", 1'b0);
      rd_chk("R6 raw unaffected", A_RAW, 1);
   endtask

   task automatic t_ack();
      wr(A_IEN, 1);
      wr(A_ACK, 32'hFFFF_FFFE);
      rd_chk("R7 bit0 clear no effect", A_RAW, 1);
      irq_chk("R7 irq held", 1'b1);
      rd_chk("R8 ack reads 0", A_ACK, 0);
      wr(A_ACK, 1);
      rd_chk("R7 cleared", A_RAW, 0);
      irq_chk("R7 irq low", 1'b0);
   endtask

   task automatic t_no_spurious();
      wr(A_CMP, 200);
      wr(A_PRESET, 200);
      rd_chk("R5 preset onto cmp", A_RAW, 0);
      wr(A_CMP, 200);
      rd_chk("R5 cmp write equal", A_RAW, 0);
      tk1();
      rd_chk("R5 step past cmp", A_RAW, 0);
   endtask

   task automatic t_set_wins();
      wr(A_PRESET, 299);
      wr(A_CMP, 300);
      wr(A_ACK, 1, 1'b1);
      rd_chk("R7 set wins count", A_COUNT, 300);
      rd_chk("R7 set wins flag", A_RAW, 1);
      irq_chk("R7 set wins irq", 1'b1);
      wr(A_ACK, 1);
   endtask

   task automatic t_preset_vs_tick();
      wr(A_PRESET, 500, 1'b1);
      rd_chk("R2 preset beats tick", A_COUNT, 500);
   endtask

   task automatic t_wrap();
      wr(A_CMP, 0);
      wr(A_PRESET, 32'hFFFF_FFFF);
      tk1();
      rd_chk("R3 wrap", A_COUNT, 0);
      rd_chk("R5 match at wrap", A_RAW, 1);
      wr(A_ACK, 1);
   endtask

   task automatic t_prescale();
      @(negedge clk);
      rst2_n = 1'b1;
      repeat (3 * DIV - 1) @(posedge clk);
      @(negedge clk);
      chk("R9 before third step", pre_rdata, 2);
      @(negedge clk);
      chk("R9 third step", pre_rdata, 3);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_preset();
      t_count();
      t_run();
      t_match();
      t_mask();
      t_ack();
      t_no_spurious();
      t_set_wins();
      t_preset_vs_tick();
      t_wrap();
      t_prescale();
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule